// File: doc/BRIEF.md
# Dual-Mode Configuration Control Interface

This block is the configuration front end of a data converter. Four host pins (chip select, serial clock, data in and data out) play one of two roles, chosen by a static strap input. With the strap low, the pins form a serial slave port. The host shifts 16-bit command words into a small bank of 8-bit mode registers and can read those registers back on an open-drain data line. With the strap high, the chip-select, clock and data-in pins are plain level inputs, and each one sets a single control bit directly.

The system clock oversamples the serial clock, chip select and data in. Each passes through a two-stage synchronizer, and an edge detector then finds the serial-clock edges. The serial clock must therefore stay below a quarter of the system clock. The bench uses a half period of 8 system clocks. The outputs are the decoded control bits for sleep, the clock duty stabilizer, the 3-bit output drive-current code, the output termination and the output test-pattern selection.

Top module: `cfgif_top`

## Requirements
- R1: After synchronous reset in serial mode (mode_par=0), every control output is 0 and sdo_low_en is 0, so the data line is released.
- R2: A serial frame is 16 bits, MSB first, sampled on serial-clock rising edges while cs_n is low. Bit 15 is the direction (0 = write), bits 14:8 are the address and bits 7:0 are the data. A write takes effect after the 16th rising edge. Register 1 holds sleep in bit 0 and the duty-stabilizer enable in bit 1. Register 2 bits 2:0 are the current code. Register 3 bit 0 is the termination enable. Register 4 bits 2:0 are the test pattern.
- R3: When bit 15 of a frame is 1, the addressed register byte is presented MSB first. Bit 7 is valid at the falling edge after the 8th rising edge, and each later bit is valid at the next falling edge, up to bit 0 at the falling edge after the 15th. sdo_low_en=1 pulls the line low for a 0, and sdo_low_en=0 releases it for a 1.
- R4: sdo_low_en stays 0 while cs_n is high, during the first 8 bits of any frame, and for all of a write frame.
- R5: A frame that ends (cs_n high) before its 16th rising edge changes no register.
- R6: A write to address 0 with data bit 7 set clears registers 1 to 4 to zero. Address 0 always reads as 0x00.
- R7: Writes to addresses 5 to 127 change no register, and reads from those addresses return 0x00.
- R8: In parallel mode (mode_par=1), o_lvds_cur is 0 (3.5 mA) when sdi is low and 4 (7.5 mA) when sdi is high. o_sleep follows the sck level and o_dcs_en follows the cs_n level. o_term_en and o_test_pat are 0, and sdo_low_en is 0.
- R9: Rising edges after the 16th in the same frame are ignored, and the frame commits its first 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_par | input | 1 | Static strap: 0 selects the serial port, 1 selects parallel levels |
| cs_n | input | 1 | Serial chip select (active low), or duty-stabilizer level in parallel mode |
| sck | input | 1 | Serial clock, or sleep level in parallel mode |
| sdi | input | 1 | Serial data in, or current-select level in parallel mode |
| sdo_low_en | output | 1 | Open-drain control: 1 pulls the data line low, 0 releases it |
| o_sleep | output | 1 | Low-power sleep |
| o_dcs_en | output | 1 | Clock duty stabilizer enable |
| o_lvds_cur | output | 3 | Output drive-current code |
| o_term_en | output | 1 | Output termination enable |
| o_test_pat | output | 3 | Output test-pattern select |

## Verification
The hardest case to reach from the ports is a frame that stops partway. One kind ends just short of the 16th edge, and the other runs past it. In both, the bench must show that the register keeps its old value, or that it holds only the first 16 bits. The bench drives its own bit-level frames with chosen lengths of 10 and 20 edges and then reads the register back. Soft resets and writes to unmapped addresses are mixed into a seeded random run of writes, and each write is followed by a readback that a bench model checks.

// File: rtl/cfgif_pkg.sv
package cfgif_pkg;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int NREG    = 5;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int HALF_W  = FRAME_W / 2;

    localparam logic [2:0] CUR_LOW  = 3'd0;
    localparam logic [2:0] CUR_HIGH = 3'd4;

    localparam logic [ADDR_W-1:0] A_CTRL = 7'd0;
    localparam logic [ADDR_W-1:0] A_PWR  = 7'd1;
    localparam logic [ADDR_W-1:0] A_CUR  = 7'd2;
    localparam logic [ADDR_W-1:0] A_TERM = 7'd3;
    localparam logic [ADDR_W-1:0] A_PAT  = 7'd4;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic       sleep;
        logic       dcs_en;
        logic [2:0] cur;
        logic       term_en;
        logic [2:0] pat;
    } ctrl_t;

    function automatic ctrl_t decode_regs(logic [DATA_W-1:0] pwr, logic [DATA_W-1:0] cur,
                                          logic [DATA_W-1:0] term, logic [DATA_W-1:0] pat);
        ctrl_t c;
        c.sleep   = pwr[0];
        c.dcs_en  = pwr[1];
        c.cur     = cur[2:0];
        c.term_en = term[0];
        c.pat     = pat[2:0];
        return c;
    endfunction

    function automatic ctrl_t decode_levels(logic cs_lvl, logic sck_lvl, logic sdi_lvl);
        ctrl_t c;
        c.sleep   = sck_lvl;
        c.dcs_en  = cs_lvl;
        c.cur     = sdi_lvl ? CUR_HIGH : CUR_LOW;
        c.term_en = 1'b0;
        c.pat     = 3'd0;
        return c;
    endfunction
endpackage

// File: rtl/cfgif_sync.sv
module cfgif_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfgif_shifter.sv
module cfgif_shifter
    import cfgif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo_low
);
    logic               sck_d;
    logic               rise;
    logic               active;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sreg;
    logic [DATA_W-1:0]  outbuf;
    logic               rd_act;
    logic               ld_pend;
    logic               wr_pend;
    frame_t             fr;

    assign active = enable & ~cs_s;
    assign rise   = sck_s & ~sck_d;
    assign fr     = frame_t'(sreg);

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt     <= '0;
            sreg    <= '0;
            outbuf  <= '0;
            rd_act  <= 1'b0;
            ld_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            ld_pend <= 1'b0;
            wr_pend <= 1'b0;
            if (ld_pend) begin
                outbuf <= rd_data;
                rd_act <= sreg[HALF_W-1];
            end
            if (rise && cnt < CNT_W'(FRAME_W)) begin
                sreg <= {sreg[FRAME_W-2:0], sdi_s};
                cnt  <= cnt + 1'b1;
                if (cnt == CNT_W'(HALF_W - 1)) ld_pend <= 1'b1;
                if (cnt >= CNT_W'(HALF_W)) outbuf <= {outbuf[DATA_W-2:0], 1'b0};
                if (cnt == CNT_W'(FRAME_W - 1)) begin
                    wr_pend <= 1'b1;
                    rd_act  <= 1'b0;
                end
            end
        end
    end

    assign rd_addr = sreg[ADDR_W-1:0];
    assign wr_en   = wr_pend & ~fr.rd;
    assign wr_addr = fr.addr;
    assign wr_data = fr.data;
    assign sdo_low = rd_act & ~outbuf[DATA_W-1];

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W));
    a_r4_release_idle: assert property (@(posedge clk) disable iff (rst)
        !active |=> !sdo_low);
    a_r5_commit_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> cnt == CNT_W'(FRAME_W));
    a_r4_release_cmd: assert property (@(posedge clk) disable iff (rst)
        (cnt < CNT_W'(HALF_W)) |-> !sdo_low);
endmodule

// File: rtl/cfgif_regbank.sv
module cfgif_regbank
    import cfgif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl
);
    logic [DATA_W-1:0] regs [NREG];
    logic              soft_rst;

    assign soft_rst = wr_en && (wr_addr == A_CTRL) && wr_data[DATA_W-1];
    assign regs[0]  = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || soft_rst)
                regs[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                regs[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 1; i < NREG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    assign ctrl = decode_regs(regs[A_PWR], regs[A_CUR], regs[A_TERM], regs[A_PAT]);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (regs[1] == '0 && regs[2] == '0 && regs[3] == '0 && regs[4] == '0));
    a_r6_soft_reset: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_CTRL && wr_data[DATA_W-1]) |=>
        (regs[1] == '0 && regs[2] == '0 && regs[3] == '0 && regs[4] == '0));
    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= ADDR_W'(NREG)) |=>
        ($stable(regs[1]) && $stable(regs[2]) && $stable(regs[3]) && $stable(regs[4])));
endmodule

// File: rtl/cfgif_top.sv
module cfgif_top
    import cfgif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_par,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    output logic       sdo_low_en,
    output logic       o_sleep,
    output logic       o_dcs_en,
    output logic [2:0] o_lvds_cur,
    output logic       o_term_en,
    output logic [2:0] o_test_pat
);
    logic [2:0]        pin_s;
    logic              cs_s, sck_s, sdi_s;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              sdo_low;
    ctrl_t             reg_ctrl;
    ctrl_t             pin_ctrl;
    ctrl_t             ctrl;

    cfgif_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d({cs_n, sck, sdi}), .q(pin_s)
    );
    assign {cs_s, sck_s, sdi_s} = pin_s;

    cfgif_shifter u_shift (
        .clk(clk), .rst(rst), .enable(~mode_par),
        .cs_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo_low(sdo_low)
    );

    cfgif_regbank u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctrl(reg_ctrl)
    );

    assign pin_ctrl = decode_levels(cs_s, sck_s, sdi_s);
    assign ctrl     = mode_par ? pin_ctrl : reg_ctrl;

    assign sdo_low_en = sdo_low;
    assign o_sleep    = ctrl.sleep;
    assign o_dcs_en   = ctrl.dcs_en;
    assign o_lvds_cur = ctrl.cur;
    assign o_term_en  = ctrl.term_en;
    assign o_test_pat = ctrl.pat;

    a_r8_par_no_drive: assert property (@(posedge clk) disable iff (rst)
        (mode_par && $past(mode_par)) |-> !sdo_low_en);
    a_r8_par_no_term: assert property (@(posedge clk) disable iff (rst)
        mode_par |-> (!o_term_en && o_test_pat == 3'd0));
endmodule

// File: tb/sim_cfgif_top.sv
module sim_cfgif_top;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_par = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo_low_en, o_sleep, o_dcs_en, o_term_en;
    logic [2:0] o_lvds_cur, o_test_pat;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [8];

    always #(CLK_P/2) clk = ~clk;

    cfgif_top u0 (
        .clk(clk), .rst(rst), .mode_par(mode_par), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo_low_en(sdo_low_en), .o_sleep(o_sleep), .o_dcs_en(o_dcs_en),
        .o_lvds_cur(o_lvds_cur), .o_term_en(o_term_en), .o_test_pat(o_test_pat)
    );

    task automatic wclk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(logic [6:0] a);
        return (a >= 7'd1 && a <= 7'd4) ? mdl[a[2:0]] : 8'h00;
    endfunction

    function automatic logic [9:0] exp_ctrl();
        return {mdl[1][0], mdl[1][1], mdl[2][2:0], mdl[3][0], mdl[4][2:0]};
    endfunction

    task automatic mdl_write(logic [6:0] a, logic [7:0] d);
        if (a == 7'd0 && d[7]) begin
            for (int i = 1; i <= 4; i++) mdl[i] = 8'h00;
        end else if (a >= 7'd1 && a <= 7'd4) begin
            mdl[a[2:0]] = d;
        end
    endtask

    // Sends nbits from the top of bits. Collects the line level before the falls after edges 8..15.
    // Flags a driven line during the command phase (R4).
    task automatic send(logic [23:0] bits, int nbits, output logic [7:0] rd, output logic cmd_drv);
        rd = 8'h00;
        cmd_drv = 1'b0;
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[23-i];
            wclk(HALF);
            sck = 1'b1;
            wclk(HALF);
            if (i < 7 && sdo_low_en) cmd_drv = 1'b1;
            if (i >= 7 && i <= 14) rd = {rd[6:0], ~sdo_low_en};
            sck = 1'b0;
        end
        wclk(HALF);
        cs_n = 1'b1;
        wclk(HALF);
    endtask

    task automatic do_write(logic [6:0] a, logic [7:0] d, string req);
        logic [7:0] r;
        logic drv;
        send({1'b0, a, d, 8'h00}, 16, r, drv);
        mdl_write(a, d);
        chk({req, " write frame keeps line released"}, {31'd0, drv | sdo_low_en}, 32'd0);
    endtask

    task automatic do_read(logic [6:0] a, string req);
        logic [7:0] r;
        logic drv;
        send({1'b1, a, 8'h00, 8'h00}, 16, r, drv);
        chk({req, " readback"}, {24'd0, r}, {24'd0, exp_rd(a)});
        chk("R4 command phase released", {31'd0, drv}, 32'd0);
        chk("R4 released after cs high", {31'd0, sdo_low_en}, 32'd0);
    endtask

    task automatic chk_outs(string req);
        chk(req, {22'd0, o_sleep, o_dcs_en, o_lvds_cur, o_term_en, o_test_pat}, {22'd0, exp_ctrl()});
    endtask

    initial begin
        logic [7:0] r;
        logic drv;
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        void'($urandom(32'h5eed_1234));

        wclk(4);
        rst = 1'b0;
        wclk(2);
        chk_outs("R1 reset outputs");
        chk("R1 line released", {31'd0, sdo_low_en}, 32'd0);

        // R2: each field in turn
        do_write(7'd1, 8'h03, "R2");
        chk_outs("R2 sleep+dcs");
        do_write(7'd2, 8'h05, "R2");
        chk_outs("R2 current code");
        do_write(7'd3, 8'h01, "R2");
        do_write(7'd4, 8'h06, "R2");
        chk_outs("R2 term+pattern");
        do_read(7'd2, "R3");
        do_write(7'd2, 8'hA5, "R3");
        do_read(7'd2, "R3 mixed bits");

        // R5: truncated at 10 edges
        send({1'b0, 7'd3, 8'h00, 8'h00}, 10, r, drv);
        do_read(7'd3, "R5 truncated frame");
        send({1'b0, 7'd1, 8'hFC, 8'h00}, 15, r, drv);
        do_read(7'd1, "R5 truncated at 15");

        // R9: 20 edges, tail ignored
        send({1'b0, 7'd4, 8'h02, 8'hF0}, 20, r, drv);
        mdl_write(7'd4, 8'h02);
        do_read(7'd4, "R9 extra edges");
        chk_outs("R9 outputs");

        // R7: unmapped
        do_write(7'd5, 8'hFF, "R7");
        do_write(7'd127, 8'h77, "R7");
        chk_outs("R7 outputs unchanged");
        do_read(7'd6, "R7 unmapped read");
        do_read(7'd1, "R7 reg1 intact");

        // R6: address 0
        do_write(7'd0, 8'h7F, "R6");
        chk_outs("R6 no bit7 no clear");
        do_read(7'd0, "R6 addr0 reads zero");
        do_write(7'd0, 8'h80, "R6");
        chk_outs("R6 soft reset");
        do_read(7'd2, "R6 cleared reg");

        // random mix
        for (int n = 0; n < 40; n++) begin
            logic [6:0] a;
            logic [7:0] d;
            a = 7'($urandom_range(0, 7));
            d = 8'($urandom);
            if (a == 7'd0 && ($urandom_range(0, 3) != 0)) d[7] = 1'b0;
            do_write(a, d, "R2 random");
            chk_outs("R2 random outputs");
            do_read(7'($urandom_range(0, 7)), "R3 random");
        end

        // R8: parallel mode
        rst = 1'b1;
        mode_par = 1'b1;
        wclk(3);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            cs_n = k[0];
            sck  = k[1];
            sdi  = k[2];
            wclk(5);
            chk("R8 parallel levels", {22'd0, o_sleep, o_dcs_en, o_lvds_cur, o_term_en, o_test_pat},
                {22'd0, sck, cs_n, (sdi ? 3'd4 : 3'd0), 1'b0, 3'd0});
            chk("R8 line released", {31'd0, sdo_low_en}, 32'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule